// File: doc/BRIEF.md
# Dual-Mode Branch Resolver

This unit resolves the control-flow effect of one 16-bit compact branch instruction per cycle for a core that also runs a 32-bit native instruction set. Each cycle it can accept the raw halfword, the address of that halfword, the link register value as currently read, a register operand already selected by the register file, and the four condition flags. From these it produces the next program counter, an optional link register write, and the instruction-set mode bit. That mode bit is 1 for compact mode and 0 for native mode, and it resets to native.

The unit also handles exception entry and exception return. On entry it saves the mode that was interrupted and forces native mode. On return it restores the saved mode.

A small state machine with three named states pairs the two halves of a long call:
- `ST_RUN` is normal operation.
- `ST_CALL_OPEN` means the first half of a long call was the last accepted instruction.
- `ST_EXC` means an exception handler is running.

The named transitions are:
- RUN→CALL_OPEN, and CALL_OPEN→CALL_OPEN, on a first half.
- CALL_OPEN→RUN on any other accepted instruction.
- RUN/CALL_OPEN→EXC on exception entry.
- EXC→RUN on exception return.

All results are registered.

Top module: `brx_unit`

## Requirements
- R1: After reset `out_valid`, `lr_we`, `pc_next` and `lr_wdata` are zero, `cmode` is 0 (native) and the state is `ST_RUN`.
- R2: An instruction with bits [15:12]=1101 and condition field [11:8] below 14 is a conditional branch. Flags are `nzcv`={N,Z,C,V}. The condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V). When the condition holds, `pc_next` = `cur_pc`+4+2·sext([7:0]), with no link write and `cmode` unchanged.
- R3: A failing conditional branch, and any 1101 pattern with condition 14 or 15, gives `pc_next` = `cur_pc`+2 with no link write and `cmode` unchanged.
- R4: Bits [15:11]=11100 is an unconditional branch: `pc_next` = `cur_pc`+4+2·sext([10:0]).
- R5: Bits [15:11]=11110 is the first half of a long call. It writes the link register with `cur_pc`+4+(sext([10:0])<<12), sets `pc_next` = `cur_pc`+2 and enters `ST_CALL_OPEN`.
- R6: Bits [15:11]=11111 is the second half of a long call. In `ST_CALL_OPEN` it sets `pc_next` = `lr_in`+2·[10:0] (zero-extended), writes the link register with (`cur_pc`+2)|1, keeps `cmode` and returns to `ST_RUN`. In `ST_RUN` it only advances `pc_next` by 2 and writes nothing.
- R7: Bits [15:11]=11101 with bit 0 clear is the mode-exchanging second half. In `ST_CALL_OPEN` it sets `pc_next` = (`lr_in`+4·[10:1]) with bits [1:0] cleared, writes the link register with (`cur_pc`+2)|1, and sets `cmode` to 0. With bit 0 set, or in `ST_RUN`, it only advances by 2.
- R8: Bits [15:7]=010001110 is a register exchange: `pc_next` = `rm_val` with bit 0 cleared, `cmode` = `rm_val`[0], no link write.
- R9: Bits [15:7]=010001111 is a register link-exchange. It behaves as R8 and also writes the link register with (`cur_pc`+2)|1.
- R10: Outside `ST_EXC`, `exc_take` wins over `in_valid`. It saves `cmode`, sets `cmode` to 0 and `pc_next` to the vector (default 8) with no link write, and enters `ST_EXC`. In `ST_EXC`, `in_valid` and `exc_take` are ignored (`out_valid` stays 0).
- R11: `exc_ret` in `ST_EXC` sets `pc_next` = `lr_in` with bit 0 cleared, restores the saved mode and returns to `ST_RUN`. Outside `ST_EXC` it is ignored.
- R12: Any other accepted halfword gives `pc_next` = `cur_pc`+2 with no link write and `cmode` unchanged. Every accepted event raises `out_valid` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A halfword is presented this cycle |
| instr | input | 16 | Raw compact instruction |
| cur_pc | input | AW | Address of the presented halfword |
| lr_in | input | AW | Current link register value |
| rm_val | input | AW | Selected register operand |
| nzcv | input | 4 | Flags {N,Z,C,V} |
| exc_take | input | 1 | Exception entry request |
| exc_ret | input | 1 | Exception return request |
| out_valid | output | 1 | Registered results are valid |
| pc_next | output | AW | Next program counter |
| lr_we | output | 1 | Link register write enable |
| lr_wdata | output | AW | Link register write data |
| cmode | output | 1 | Mode bit, 1 compact, 0 native |

## Verification
Every result (`pc_next`, `lr_we`, `lr_wdata`, `out_valid`, and the new `cmode`) appears at the first rising edge after the stimulus is presented, so each is due exactly one cycle after the stimulus. The bench applies each stimulus on a falling edge. It samples one nanosecond after the following rising edge and withdraws the stimulus on the next falling edge, so every stimulus is seen by exactly one edge. Mode and pairing state persist across scenarios, so later checks also confirm that earlier events left `cmode` and the call-pairing state where the requirements put them.

// File: rtl/brx_pkg.sv
package brx_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_CALL_OPEN = 2'd1,
        ST_EXC       = 2'd2
    } brx_state_e;

    typedef enum logic [2:0] {
        C_OTHER = 3'd0,
        C_BCOND = 3'd1,
        C_BUNC  = 3'd2,
        C_LONG1 = 3'd3,
        C_LONG2 = 3'd4,
        C_XCH2  = 3'd5,
        C_BXR   = 3'd6,
        C_BLXR  = 3'd7
    } brx_cls_e;

endpackage

// File: rtl/brx_decode.sv
module brx_decode
    import brx_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [15:0]   instr,
    output brx_cls_e      cls,
    output logic [3:0]    cond,
    output logic [AW-1:0] off_cond,
    output logic [AW-1:0] off_unc,
    output logic [AW-1:0] off_hi,
    output logic [AW-1:0] off_lo,
    output logic [AW-1:0] off_xch
);
    localparam int SX8  = AW - 9;
    localparam int SX11 = AW - 12;
    localparam int SXHI = AW - 23;

    assign cond     = instr[11:8];
    assign off_cond = {{SX8{instr[7]}}, instr[7:0], 1'b0};
    assign off_unc  = {{SX11{instr[10]}}, instr[10:0], 1'b0};
    assign off_hi   = {{SXHI{instr[10]}}, instr[10:0], 12'b0};
    assign off_lo   = {{SX11{1'b0}}, instr[10:0], 1'b0};
    assign off_xch  = {{SX11{1'b0}}, instr[10:1], 2'b00};

    always_comb begin
        cls = C_OTHER;
        if (instr[15:12] == 4'b1101) begin
            cls = (instr[11:9] == 3'b111) ? C_OTHER : C_BCOND;
        end else if (instr[15:11] == 5'b11100) begin
            cls = C_BUNC;
        end else if (instr[15:11] == 5'b11101) begin
            cls = instr[0] ? C_OTHER : C_XCH2;
        end else if (instr[15:11] == 5'b11110) begin
            cls = C_LONG1;
        end else if (instr[15:11] == 5'b11111) begin
            cls = C_LONG2;
        end else if (instr[15:7] == 9'b010001110) begin
            cls = C_BXR;
        end else if (instr[15:7] == 9'b010001111) begin
            cls = C_BLXR;
        end
    end
endmodule

// File: rtl/brx_cond.sv
module brx_cond (
    input  logic [3:0] cond,
    input  logic [3:0] nzcv,
    output logic       pass
);
    logic n, z, c, v;
    assign {n, z, c, v} = nzcv;

    always_comb begin
        unique case (cond)
            4'd0:    pass = z;
            4'd1:    pass = !z;
            4'd2:    pass = c;
            4'd3:    pass = !c;
            4'd4:    pass = n;
            4'd5:    pass = !n;
            4'd6:    pass = v;
            4'd7:    pass = !v;
            4'd8:    pass = c && !z;
            4'd9:    pass = !c || z;
            4'd10:   pass = (n == v);
            4'd11:   pass = (n != v);
            4'd12:   pass = !z && (n == v);
            4'd13:   pass = z || (n != v);
            4'd14:   pass = 1'b1;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/brx_unit.sv
module brx_unit
    import brx_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int unsigned EXC_VEC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   instr,
    input  logic [AW-1:0] cur_pc,
    input  logic [AW-1:0] lr_in,
    input  logic [AW-1:0] rm_val,
    input  logic [3:0]    nzcv,
    input  logic          exc_take,
    input  logic          exc_ret,
    output logic          out_valid,
    output logic [AW-1:0] pc_next,
    output logic          lr_we,
    output logic [AW-1:0] lr_wdata,
    output logic          cmode
);
    localparam logic [AW-1:0] MASK_B0  = ~AW'(1);
    localparam logic [AW-1:0] MASK_B10 = ~AW'(3);
    localparam logic [AW-1:0] VEC      = AW'(EXC_VEC);

    brx_state_e     state, state_d;
    logic           mode_d, saved_mode, saved_d;
    logic           ov_d, lwe_d;
    logic [AW-1:0]  pc_d, lwd_d;

    brx_cls_e       cls;
    logic [3:0]     cond;
    logic           pass;
    logic [AW-1:0]  off_cond, off_unc, off_hi, off_lo, off_xch;
    logic [AW-1:0]  base4, seq2, link_ret;
    logic           fire;

    brx_decode #(.AW(AW)) u_dec (
        .instr    (instr),
        .cls      (cls),
        .cond     (cond),
        .off_cond (off_cond),
        .off_unc  (off_unc),
        .off_hi   (off_hi),
        .off_lo   (off_lo),
        .off_xch  (off_xch)
    );

    brx_cond u_cond (
        .cond (cond),
        .nzcv (nzcv),
        .pass (pass)
    );

    assign base4    = cur_pc + AW'(4);
    assign seq2     = cur_pc + AW'(2);
    assign link_ret = seq2 | AW'(1);
    assign fire     = in_valid && !exc_take && (state != ST_EXC);

    always_comb begin
        state_d = state;
        mode_d  = cmode;
        saved_d = saved_mode;
        ov_d    = 1'b0;
        lwe_d   = 1'b0;
        pc_d    = pc_next;
        lwd_d   = lr_wdata;
        unique case (state)
            ST_RUN, ST_CALL_OPEN: begin
                if (exc_take) begin
                    saved_d = cmode;
                    mode_d  = 1'b0;
                    pc_d    = VEC;
                    ov_d    = 1'b1;
                    state_d = ST_EXC;
                end else if (in_valid) begin
                    ov_d    = 1'b1;
                    pc_d    = seq2;
                    state_d = ST_RUN;
                    unique case (cls)
                        C_BCOND: if (pass) pc_d = base4 + off_cond;
                        C_BUNC:  pc_d = base4 + off_unc;
                        C_LONG1: begin
                            lwe_d   = 1'b1;
                            lwd_d   = base4 + off_hi;
                            state_d = ST_CALL_OPEN;
                        end
                        C_LONG2: if (state == ST_CALL_OPEN) begin
                            pc_d  = lr_in + off_lo;
                            lwe_d = 1'b1;
                            lwd_d = link_ret;
                        end
                        C_XCH2: if (state == ST_CALL_OPEN) begin
                            pc_d   = (lr_in + off_xch) & MASK_B10;
                            lwe_d  = 1'b1;
                            lwd_d  = link_ret;
                            mode_d = 1'b0;
                        end
                        C_BXR: begin
                            pc_d   = rm_val & MASK_B0;
                            mode_d = rm_val[0];
                        end
                        C_BLXR: begin
                            pc_d   = rm_val & MASK_B0;
                            mode_d = rm_val[0];
                            lwe_d  = 1'b1;
                            lwd_d  = link_ret;
                        end
                        default: ;
                    endcase
                end
            end
            ST_EXC: begin
                if (exc_ret) begin
                    ov_d    = 1'b1;
                    pc_d    = lr_in & MASK_B0;
                    mode_d  = saved_mode;
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            cmode      <= 1'b0;
            saved_mode <= 1'b0;
        end else begin
            state      <= state_d;
            cmode      <= mode_d;
            saved_mode <= saved_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pc_next   <= '0;
            lr_we     <= 1'b0;
            lr_wdata  <= '0;
        end else begin
            out_valid <= ov_d;
            pc_next   <= pc_d;
            lr_we     <= lwe_d;
            lr_wdata  <= lwd_d;
        end
    end

    AST_SKIP_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && cls == C_BCOND && !pass) |-> (!lr_we && $stable(cmode))); // R3
    AST_LINK_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && (cls == C_LONG2 || cls == C_XCH2) && state == ST_CALL_OPEN)
        |-> (lr_we && lr_wdata[0])); // R6
    AST_STRAY_NO_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && cls == C_LONG2 && state == ST_RUN) |-> !lr_we); // R6
    AST_XCH_WORD_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && cls == C_XCH2 && state == ST_CALL_OPEN)
        |-> (pc_next[1:0] == 2'b00 && !cmode)); // R7
    AST_REGX_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && (cls == C_BXR || cls == C_BLXR))
        |-> (!pc_next[0] && cmode == $past(rm_val[0]))); // R8
    AST_EXC_TO_NATIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exc_take && state != ST_EXC) |-> (out_valid && !cmode && !lr_we)); // R10
    AST_EXC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_EXC && !exc_ret) |-> !out_valid); // R10
    AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_EXC && exc_ret) |-> (cmode == $past(saved_mode))); // R11
endmodule

// File: tb/sim_brx_unit.sv
module sim_brx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] cur_pc = '0, lr_in = '0, rm_val = '0;
    logic [3:0]  nzcv = '0;
    logic        exc_take = 1'b0, exc_ret = 1'b0;
    logic        out_valid, lr_we, cmode;
    logic [31:0] pc_next, lr_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    brx_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .cur_pc(cur_pc), .lr_in(lr_in), .rm_val(rm_val), .nzcv(nzcv),
        .exc_take(exc_take), .exc_ret(exc_ret), .out_valid(out_valid),
        .pc_next(pc_next), .lr_we(lr_we), .lr_wdata(lr_wdata), .cmode(cmode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] ins, input logic [31:0] pc, input logic [31:0] lr,
                        input logic [31:0] rm, input logic [3:0] fl,
                        input logic v, input logic et, input logic er);
        @(negedge clk);
        instr = ins; cur_pc = pc; lr_in = lr; rm_val = rm; nzcv = fl;
        in_valid = v; exc_take = et; exc_ret = er;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0; exc_take = 1'b0; exc_ret = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 lr_we", {31'b0, lr_we}, 32'd0);
        chk("R1 pc_next", pc_next, 32'd0);
        chk("R1 cmode", {31'b0, cmode}, 32'd0);
    endtask

    task automatic t_cond();
        step(16'hD010, 32'h1000, 0, 0, 4'b0100, 1, 0, 0);
        chk("R2 EQ taken pc", pc_next, 32'h1024);
        chk("R2 EQ no link", {31'b0, lr_we}, 32'd0);
        chk("R12 valid", {31'b0, out_valid}, 32'd1);
        step(16'hD1F0, 32'h1000, 0, 0, 4'b0000, 1, 0, 0);
        chk("R2 NE backward pc", pc_next, 32'h0FE4);
        step(16'hD802, 32'h3000, 0, 0, 4'b0010, 1, 0, 0);
        chk("R2 HI taken pc", pc_next, 32'h3008);
        step(16'hDC05, 32'h2000, 0, 0, 4'b1000, 1, 0, 0);
        chk("R3 GT false pc", pc_next, 32'h2002);
        chk("R3 GT false no link", {31'b0, lr_we}, 32'd0);
        step(16'hDE05, 32'h2100, 0, 0, 4'b0000, 1, 0, 0);
        chk("R3 cond14 advance", pc_next, 32'h2102);
    endtask

    task automatic t_unc();
        step(16'hE005, 32'h0100, 0, 0, 0, 1, 0, 0);
        chk("R4 fwd pc", pc_next, 32'h010E);
        step(16'hE7FE, 32'h0100, 0, 0, 0, 1, 0, 0);
        chk("R4 back pc", pc_next, 32'h0100);
    endtask

    task automatic t_long();
        step(16'hF001, 32'h8000, 0, 0, 0, 1, 0, 0);
        chk("R5 lr data", lr_wdata, 32'h9004);
        chk("R5 lr_we", {31'b0, lr_we}, 32'd1);
        chk("R5 pc", pc_next, 32'h8002);
        step(16'hF810, 32'h8002, 32'h9004, 0, 0, 1, 0, 0);
        chk("R6 pc", pc_next, 32'h9024);
        chk("R6 lr data", lr_wdata, 32'h8005);
        chk("R6 lr_we", {31'b0, lr_we}, 32'd1);
        step(16'hF7FF, 32'h8000, 0, 0, 0, 1, 0, 0);
        chk("R5 negative lr", lr_wdata, 32'h7004);
        step(16'h1C08, 32'h8002, 0, 0, 0, 1, 0, 0);
        step(16'hF810, 32'h8004, 32'h9000, 0, 0, 1, 0, 0);
        chk("R6 broken pair pc", pc_next, 32'h8006);
        chk("R6 broken pair no link", {31'b0, lr_we}, 32'd0);
        step(16'hF810, 32'h0500, 32'h9000, 0, 0, 1, 0, 0);
        chk("R6 stray pc", pc_next, 32'h0502);
        chk("R6 stray no link", {31'b0, lr_we}, 32'd0);
    endtask

    task automatic t_regx();
        step(16'h4708, 32'h0300, 0, 32'h4001, 0, 1, 0, 0);
        chk("R8 pc", pc_next, 32'h4000);
        chk("R8 mode compact", {31'b0, cmode}, 32'd1);
        chk("R8 no link", {31'b0, lr_we}, 32'd0);
        step(16'h4708, 32'h4000, 0, 32'h5000, 0, 1, 0, 0);
        chk("R8 to native pc", pc_next, 32'h5000);
        chk("R8 to native mode", {31'b0, cmode}, 32'd0);
        step(16'h4790, 32'h0200, 0, 32'h6001, 0, 1, 0, 0);
        chk("R9 pc", pc_next, 32'h6000);
        chk("R9 mode", {31'b0, cmode}, 32'd1);
        chk("R9 lr data", lr_wdata, 32'h0203);
        chk("R9 lr_we", {31'b0, lr_we}, 32'd1);
    endtask

    task automatic t_xch();
        step(16'hF001, 32'h8000, 0, 0, 0, 1, 0, 0);
        step(16'hE820, 32'h8002, 32'h9006, 0, 0, 1, 0, 0);
        chk("R7 pc", pc_next, 32'h9044);
        chk("R7 lr data", lr_wdata, 32'h8005);
        chk("R7 mode native", {31'b0, cmode}, 32'd0);
        step(16'h4708, 32'h9044, 0, 32'h0A01, 0, 1, 0, 0);
        step(16'hF001, 32'h8000, 0, 0, 0, 1, 0, 0);
        step(16'hE821, 32'h8002, 32'h9006, 0, 0, 1, 0, 0);
        chk("R7 odd field advance", pc_next, 32'h8004);
        chk("R7 odd field mode kept", {31'b0, cmode}, 32'd1);
    endtask

    task automatic t_exc();
        step(16'h4708, 32'h0040, 0, 32'h0A01, 0, 1, 1, 0);
        chk("R10 vector", pc_next, 32'h0000_0008);
        chk("R10 mode native", {31'b0, cmode}, 32'd0);
        chk("R10 no link", {31'b0, lr_we}, 32'd0);
        step(16'h4708, 32'h0008, 0, 32'h0B01, 0, 1, 0, 0);
        chk("R10 ignored valid", {31'b0, out_valid}, 32'd0);
        chk("R10 ignored mode", {31'b0, cmode}, 32'd0);
        step(16'h0000, 32'h0010, 32'h7777, 0, 0, 0, 0, 1);
        chk("R11 pc", pc_next, 32'h7776);
        chk("R11 mode restored", {31'b0, cmode}, 32'd1);
        step(16'h0000, 32'h0010, 32'h1235, 0, 0, 0, 0, 1);
        chk("R11 ret outside ignored", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_other();
        step(16'h1C08, 32'h0040, 0, 0, 0, 1, 0, 0);
        chk("R12 pc", pc_next, 32'h0042);
        chk("R12 no link", {31'b0, lr_we}, 32'd0);
        chk("R12 mode kept", {31'b0, cmode}, 32'd1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_cond();
        t_unc();
        t_long();
        t_regx();
        t_xch();
        t_exc();
        t_other();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule